// File: doc/BRIEF.md
# Floating-point operand unpacker

This unit turns a 64-bit floating-point register image into the working form that later arithmetic stages use. A 3-bit kind select says how to read the image: as a 64-bit signed integer, a 32-bit signed integer in the low half, a single-precision value in the high half, or a double-precision value across the whole word. The result has a sign bit, a signed unbiased exponent, a 64-bit mantissa whose leading one sits in bit 63, and a class code.

Integers and denormals go through one shared leading-zero normalizer. Signalling NaNs are made quiet as they are unpacked. They get a class code of their own and raise an invalid-operand flag. The result is registered, so it appears one clock after the request.

Kind codes: 0 = 64-bit integer, 1 = 32-bit integer, 2 = single, 3 = double, 4..7 = unsupported. Class codes: 0 = ZERO, 1 = NUMBER, 2 = INFINITY, 3 = QNAN, 4 = SNAN. The exponent output is a 13-bit two's-complement value.

Top module: `fpu_unpack`

## Requirements
- R1: The sign output is bit 31 of the image for kind 1, and bit 63 for kinds 0, 2 and 3.
- R2: An integer input (kind 0 or kind 1) equal to zero gives class 0 (ZERO), with exponent 0 and mantissa 0.
- R3: A nonzero integer is first turned into its magnitude by two's-complement negation when it is negative. The magnitude is shifted left until bit 63 is set, and the exponent equals the bit index of the magnitude's leading one. The most negative value of each width unpacks with mantissa 0x8000_0000_0000_0000.
- R4: A float whose exponent field and fraction are both zero gives class 0, with exponent 0 and mantissa 0.
- R5: A float with a zero exponent field and a nonzero fraction is a denormal. It gives class 1 with no hidden one. The fraction is shifted left until bit 63 is set, and the exponent is (1 - bias) minus that shift.
- R6: A normal float gives class 1 and exponent (field - bias). The mantissa is the hidden one in bit 63 with the fraction left-aligned from bit 62 downward. Single uses an 8-bit field, bias 127 and a 23-bit fraction. Double uses an 11-bit field, bias 1023 and a 52-bit fraction.
- R7: An all-ones exponent field with a zero fraction gives class 2 (INFINITY), with exponent 0 and mantissa 0.
- R8: An all-ones exponent field with a nonzero fraction whose top bit is set gives class 3 (QNAN). The fraction is left-aligned from bit 62, the exponent is 0 and the invalid flag stays low.
- R9: An all-ones exponent field with a nonzero fraction whose top bit is clear gives class 4 (SNAN). Mantissa bit 62 is forced to one and the invalid flag is raised. The invalid flag is never high for any other class.
- R10: Kind codes 4 to 7 raise the illegal-kind output and give class 0. Sign, exponent, mantissa and invalid flag are all zero.
- R11: Outputs update one clock after an edge where in_valid is high, and out_valid then follows in_valid. While in_valid is low, the data outputs hold their previous values. Reset clears every output to zero.
- R12: The sticky output is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_word | input | 64 | Register image |
| in_kind | input | 3 | Format select |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_sign | output | 1 | Operand sign |
| out_exp | output | 13 | Unbiased exponent, two's complement |
| out_mant | output | 64 | Mantissa, leading one in bit 63 |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Signalling NaN seen |
| out_badkind | output | 1 | Unsupported kind code |
| out_sticky | output | 1 | Sticky bit, cleared |

## Verification
The assertions assume that in_kind and in_word are stable and known on every edge where in_valid is high. They also assume that reset is held for at least one edge before the first request. The bench drives all inputs on the falling clock edge and starts requests only after reset has been released. Its random words draw kind codes across the full 0 to 7 range. It often forces the exponent field to zero or all-ones, so that denormals, infinities and both kinds of NaN come up well beyond the directed cases.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

    parameter int WORD_W = 64;
    parameter int MANT_W = 64;
    parameter int EXP_W  = 13;
    parameter int KIND_W = 3;

    localparam int SGL_EB = 8;
    localparam int SGL_FB = 23;
    localparam int DBL_EB = 11;
    localparam int DBL_FB = 52;
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(MANT_W + 1);

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } op_class_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_I64 = 3'd0,
        KIND_I32 = 3'd1,
        KIND_SGL = 3'd2,
        KIND_DBL = 3'd3
    } op_kind_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        op_class_e         cls;
    } operand_t;

    function automatic logic [MANT_W-1:0] top_bit_mask();
        return {1'b1, {(MANT_W-1){1'b0}}};
    endfunction

    function automatic logic [MANT_W-1:0] quiet_bit_mask();
        return {2'b01, {(MANT_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/fpu_lzc.sv
module fpu_lzc
    import fpu_unpack_pkg::*;
#(
    parameter int W  = MANT_W,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    logic seen;

    always_comb begin
        count = CW'(W);
        seen  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen && vec[i]) begin
                count = CW'(W - 1 - i);
                seen  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpu_int_split.sv
module fpu_int_split
    import fpu_unpack_pkg::*;
#(
    parameter int IW = 64
) (
    input  logic [IW-1:0] val,
    output operand_t      pre
);
    logic [IW-1:0] mag;

    always_comb begin
        mag = val[IW-1] ? ((~val) + IW'(1)) : val;
        pre = '0;
        if (mag == '0) begin
            pre.cls = CLS_ZERO;
        end else begin
            pre.cls  = CLS_NUM;
            pre.exp  = EXP_W'(MANT_W - 1);
            pre.mant = MANT_W'(mag);
        end
    end
endmodule

// File: rtl/fpu_fmt_split.sv
module fpu_fmt_split
    import fpu_unpack_pkg::*;
#(
    parameter int EB = SGL_EB,
    parameter int FB = SGL_FB
) (
    input  logic [EB+FB-1:0] body,
    output operand_t         pre
);
    localparam int BIAS = (1 << (EB - 1)) - 1;
    localparam int PAD  = MANT_W - 1 - FB;

    logic [EB-1:0]     efield;
    logic [FB-1:0]     frac;
    logic [MANT_W-1:0] frac_al;

    assign efield  = body[EB+FB-1:FB];
    assign frac    = body[FB-1:0];
    assign frac_al = {1'b0, frac, {PAD{1'b0}}};

    always_comb begin
        pre = '0;
        if (efield == '0) begin
            if (frac != '0) begin
                pre.cls  = CLS_NUM;
                pre.exp  = EXP_W'(1 - BIAS);
                pre.mant = frac_al;
            end else begin
                pre.cls  = CLS_ZERO;
            end
        end else if (efield == '1) begin
            if (frac != '0) begin
                pre.cls  = CLS_QNAN;
                pre.mant = frac_al;
            end else begin
                pre.cls  = CLS_INF;
            end
        end else begin
            pre.cls  = CLS_NUM;
            pre.exp  = EXP_W'(efield) - EXP_W'(BIAS);
            pre.mant = frac_al | top_bit_mask();
        end
    end
endmodule

// File: rtl/fpu_norm.sv
module fpu_norm
    import fpu_unpack_pkg::*;
(
    input  operand_t pre,
    output operand_t post
);
    logic [CNT_W-1:0] lz;

    fpu_lzc #(.W(MANT_W), .CW(CNT_W)) u_lzc (
        .vec   (pre.mant),
        .count (lz)
    );

    always_comb begin
        post = pre;
        if (pre.cls == CLS_NUM) begin
            post.mant = pre.mant << lz;
            post.exp  = pre.exp - EXP_W'(lz);
        end
    end
endmodule

// File: rtl/fpu_unpack.sv
module fpu_unpack
    import fpu_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [KIND_W-1:0] in_kind,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic [2:0]        out_class,
    output logic              out_invalid,
    output logic              out_badkind,
    output logic              out_sticky
);
    operand_t pre_i64, pre_i32, pre_sgl, pre_dbl;
    operand_t pre_sel, normed, fin;
    logic     inv_d, bad_d;
    operand_t q_op;
    logic     q_valid, q_inv, q_bad;

    fpu_int_split #(.IW(WORD_W)) u_i64 (.val(in_word), .pre(pre_i64));
    fpu_int_split #(.IW(HALF_W)) u_i32 (.val(in_word[HALF_W-1:0]), .pre(pre_i32));

    fpu_fmt_split #(.EB(SGL_EB), .FB(SGL_FB)) u_sgl (
        .body (in_word[WORD_W-2:HALF_W]),
        .pre  (pre_sgl)
    );
    fpu_fmt_split #(.EB(DBL_EB), .FB(DBL_FB)) u_dbl (
        .body (in_word[WORD_W-2:0]),
        .pre  (pre_dbl)
    );

    always_comb begin
        bad_d   = 1'b0;
        pre_sel = '0;
        case (in_kind)
            KIND_I64: begin
                pre_sel      = pre_i64;
                pre_sel.sign = in_word[WORD_W-1];
            end
            KIND_I32: begin
                pre_sel      = pre_i32;
                pre_sel.sign = in_word[HALF_W-1];
            end
            KIND_SGL: begin
                pre_sel      = pre_sgl;
                pre_sel.sign = in_word[WORD_W-1];
            end
            KIND_DBL: begin
                pre_sel      = pre_dbl;
                pre_sel.sign = in_word[WORD_W-1];
            end
            default: bad_d = 1'b1;
        endcase
    end

    fpu_norm u_norm (.pre(pre_sel), .post(normed));

    always_comb begin
        fin   = normed;
        inv_d = 1'b0;
        if (normed.cls == CLS_QNAN && !normed.mant[MANT_W-2]) begin
            fin.mant = normed.mant | quiet_bit_mask();
            fin.cls  = CLS_SNAN;
            inv_d    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_op    <= '0;
            q_inv   <= 1'b0;
            q_bad   <= 1'b0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_op  <= fin;
                q_inv <= inv_d;
                q_bad <= bad_d;
            end
        end
    end

    assign out_valid   = q_valid;
    assign out_sign    = q_op.sign;
    assign out_exp     = q_op.exp;
    assign out_mant    = q_op.mant;
    assign out_class   = q_op.cls;
    assign out_invalid = q_inv;
    assign out_badkind = q_bad;
    assign out_sticky  = 1'b0;
endmodule

// File: rtl/fpu_unpack_chk.sv
module fpu_unpack_chk
    import fpu_unpack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic [KIND_W-1:0] in_kind,
    input logic              out_valid,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant,
    input logic [2:0]        out_class,
    input logic              out_invalid,
    input logic              out_badkind,
    input logic              out_sticky
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_mant) && $stable(out_exp) && $stable(out_class)));

    a_r3_leading_one: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 3'd1) |-> out_mant[MANT_W-1]);

    a_r9_flag_only_snan: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_invalid == (out_class == 3'd4)));

    a_r9_nan_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_class == 3'd3 || out_class == 3'd4)) |-> out_mant[MANT_W-2]);

    a_r10_bad_kind: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind[KIND_W-1]) |=> (out_badkind && out_class == 3'd0 && !out_invalid));

    a_r2_int_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 3'd0 && in_word == '0) |=> (out_class == 3'd0 && out_mant == '0));
endmodule

bind fpu_unpack fpu_unpack_chk u_chk (.*);

// File: tb/fpu_unpack_test.sv
module fpu_unpack_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic [2:0]  in_kind = '0;
    logic        out_valid, out_sign, out_invalid, out_badkind, out_sticky;
    logic [12:0] out_exp;
    logic [63:0] out_mant;
    logic [2:0]  out_class;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    fpu_unpack uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_kind(in_kind), .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_class(out_class),
        .out_invalid(out_invalid), .out_badkind(out_badkind),
        .out_sticky(out_sticky)
    );

    function automatic int msb_of(input logic [63:0] v);
        int p = -1;
        for (int i = 0; i < 64; i++) if (v[i]) p = i;
        return p;
    endfunction

    function automatic void model(input logic [63:0] w, input logic [2:0] k,
                                  output logic s, output logic [12:0] e,
                                  output logic [63:0] m, output logic [2:0] c,
                                  output logic inv, output logic bad,
                                  output string tag);
        logic [63:0] v, mag, fr;
        int eb, fb, bias, ef, p, ee;
        s = 0; e = 0; m = 0; c = 0; inv = 0; bad = 0; tag = "R1";
        if (k == 3'd0 || k == 3'd1) begin
            if (k == 3'd0) begin v = w; s = w[63]; end
            else begin v = {{32{w[31]}}, w[31:0]}; s = w[31]; end
            mag = s ? (~v + 64'd1) : v;
            if (mag == 0) tag = "R2";
            else begin
                p = msb_of(mag); m = mag << (63 - p); e = 13'(p); c = 1; tag = "R3";
            end
        end else if (k == 3'd2 || k == 3'd3) begin
            if (k == 3'd2) begin eb = 8; fb = 23; end else begin eb = 11; fb = 52; end
            bias = (1 << (eb - 1)) - 1;
            s  = w[63];
            ef = int'((w[62:0] >> fb) & ((64'd1 << eb) - 1));
            fr = (w & ((64'd1 << fb) - 1)) << (63 - fb);
            if (k == 3'd2) begin
                ef = int'(w[62:55]);
                fr = {1'b0, w[54:32], 40'd0};
            end
            if (ef == 0) begin
                if (fr == 0) tag = "R4";
                else begin
                    p = msb_of(fr); m = fr << (63 - p);
                    ee = 1 - bias - (63 - p); e = 13'(ee); c = 1; tag = "R5";
                end
            end else if (ef == (1 << eb) - 1) begin
                if (fr == 0) begin c = 2; tag = "R7"; end
                else if (fr[62]) begin m = fr; c = 3; tag = "R8"; end
                else begin m = fr | (64'd1 << 62); c = 4; inv = 1; tag = "R9"; end
            end else begin
                ee = ef - bias; e = 13'(ee); m = fr | (64'd1 << 63); c = 1; tag = "R6";
            end
        end else begin
            bad = 1; tag = "R10";
        end
    endfunction

    task automatic apply(input logic [63:0] w, input logic [2:0] k);
        logic s, inv, bad;
        logic [12:0] e;
        logic [63:0] m;
        logic [2:0] c;
        string tag;
        model(w, k, s, e, m, c, inv, bad, tag);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_kind = k;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b1 || out_sign !== s || out_exp !== e || out_mant !== m ||
            out_class !== c || out_invalid !== inv || out_badkind !== bad || out_sticky !== 1'b0) begin
            miscompares++;
            $display("FAIL %s (R12 sticky, R11 valid) word=%h kind=%0d actual v=%b s=%b e=%h m=%h c=%0d inv=%b bad=%b st=%b expected v=1 s=%b e=%h m=%h c=%0d inv=%b bad=%b st=0",
                     tag, w, k, out_valid, out_sign, out_exp, out_mant, out_class, out_invalid,
                     out_badkind, out_sticky, s, e, m, c, inv, bad);
        end
    endtask

    task automatic check_hold(input logic [63:0] w, input logic [2:0] k);
        logic [63:0] m0; logic [12:0] e0; logic [2:0] c0; logic s0;
        m0 = out_mant; e0 = out_exp; c0 = out_class; s0 = out_sign;
        @(negedge clk);
        in_valid = 1'b0; in_word = w; in_kind = k;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_mant !== m0 || out_exp !== e0 || out_class !== c0 || out_sign !== s0) begin
            miscompares++;
            $display("FAIL R11 hold actual v=%b m=%h e=%h c=%0d expected v=0 m=%h e=%h c=%0d",
                     out_valid, out_mant, out_exp, out_class, m0, e0, c0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R11 watchdog actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] w;
        logic [2:0] k;
        int r;
        r = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 0 || out_mant !== 0 || out_exp !== 0 || out_class !== 0 ||
            out_invalid !== 0 || out_badkind !== 0 || out_sign !== 0) begin
            miscompares++;
            $display("FAIL R11 reset actual v=%b m=%h c=%0d expected all zero", out_valid, out_mant, out_class);
        end
        rst = 1'b0;

        apply(64'd0, 3'd0);                          // R2
        apply(64'hFFFF_FFFF_0000_0000, 3'd1);        // R2 low half zero
        apply(64'hFFFF_FFFF_FFFF_FFFF, 3'd0);        // R3 minus one
        apply(64'h8000_0000_0000_0000, 3'd0);        // R3 most negative
        apply(64'h0000_0000_8000_0000, 3'd1);        // R3 most negative 32-bit, R1
        apply(64'h0000_0000_0000_0005, 3'd1);        // R3
        apply(64'h3F80_0000_0000_0000, 3'd2);        // R6 single 1.0
        apply(64'hC000_0000_0000_0000, 3'd3);        // R6 double -2.0, R1
        apply(64'h8000_0000_0000_0000, 3'd2);        // R4 negative zero
        apply(64'h0000_0001_0000_0000, 3'd2);        // R5 smallest single
        apply(64'h0000_0000_0000_0001, 3'd3);        // R5 smallest double
        apply(64'h7F80_0000_0000_0000, 3'd2);        // R7
        apply(64'hFFF0_0000_0000_0000, 3'd3);        // R7
        apply(64'h7FC0_0001_0000_0000, 3'd2);        // R8
        apply(64'h7FF0_0000_0000_0001, 3'd3);        // R9
        apply(64'h7F80_0001_0000_0000, 3'd2);        // R9
        apply(64'h7FF8_0000_0000_0000, 3'd5);        // R10
        check_hold(64'h1234_5678_9ABC_DEF0, 3'd3);   // R11
        apply(64'hFFFF_FFFF_FFFF_FFFF, 3'd7);        // R10

        for (int n = 0; n < 600; n++) begin
            w = {$urandom, $urandom};
            r = $urandom % 16;
            k = (r < 3) ? 3'd0 : (r < 6) ? 3'd1 : (r < 10) ? 3'd2 : (r < 15) ? 3'd3 : 3'($urandom % 8);
            r = $urandom % 6;
            if (k == 3'd2 && r == 0) w[62:55] = 8'h00;
            if (k == 3'd2 && r == 1) w[62:55] = 8'hFF;
            if (k == 3'd3 && r == 0) w[62:52] = 11'h000;
            if (k == 3'd3 && r == 1) w[62:52] = 11'h7FF;
            if (r == 2) w = w >> ($urandom % 64);
            apply(w, k);
            if (n % 97 == 0) check_hold(~w, 3'($urandom % 8));
        end

        @(negedge clk);
        in_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule